// File: doc/BRIEF.md
# Two-Wire Audio Control Register Slave

This block is a slave on a two-wire serial bus. It holds the control settings of a sound decoder: the output matrix mode, mute, a test enable and a five-bit separation trim. A controller writes it with three bytes: the device address, a function byte whose top three bits pick the register, and a data byte whose upper bits carry the new value. A controller reads it with the read address, one byte the slave ignores, and one byte the slave sends back. That byte encodes the broadcast mode detected elsewhere on the chip.

The bus lines are oversampled by a system clock at least eight times the bit rate. They pass through synchronizers and edge detectors. The slave drives the data line only as an open-drain pull-down. A pin picks one of two device addresses, so two copies can share a bus. Any function byte is acknowledged once the address matches, but a function code that this block does not store leaves every register unchanged.

Top module: `tw_ctrl_regs`

## Requirements
- R1: With `addr_sel_i` high the device answers write address 84h and read address 85h; with it low it answers 86h and 87h.
- R2: The slave pulls the data line low for the ninth clock of each accepted byte and releases it after that clock falls; after a stop it does not pull the line.
- R3: A start condition (data falling while clock high) restarts byte reception at the address byte, at any point, including mid-byte.
- R4: Bytes are received MSB first, and the function byte's bits 7:5 select the register: 000 mode, 001 mute, 010 test, 100 separation trim.
- R5: A mode write loads data bits 7:6 into `mode_o` (bit 1 = data bit 7): 00 mono, 10 stereo, 01 bilingual, 11 sub.
- R6: A mute write loads data bit 7 into `mute_o` (1 = muted); a test write loads data bit 7 into `test_o`.
- R7: A separation write loads data bits 7:3 into `sep_adj_o`.
- R8: Function codes 011, 101, 110 and 111 are acknowledged but change no output register.
- R9: A read ignores the second byte and sends the byte `{4'b0000, code}` MSB first, where code is 0011 for `det_mode_i`=00 (mono), 0110 for 01 (stereo) and 1001 for 10 (bilingual); `det_mode_i`=11 (nothing detected) sends 00h.
- R10: After reset the mode, mute and test registers are 0 and `sep_adj_o` is 10000b.
- R11: A register changes only when the full third byte of a write has been received; a write cut short by a start changes nothing.
- R12: A byte with a non-matching address gets no acknowledge, and the slave ignores all bytes that follow it until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Address select: 1 gives 84h/85h, 0 gives 86h/87h |
| det_mode_i | input | 2 | Detected broadcast: 00 mono, 01 stereo, 10 bilingual, 11 none |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| mode_o | output | 2 | Matrix mode register |
| mute_o | output | 1 | Mute register |
| test_o | output | 1 | Test enable register |
| sep_adj_o | output | SEP_W | Separation trim register |

## Verification
The bench goes after the function codes that are acknowledged but not stored. A design that decoded only part of the function field would overwrite the mode or trim from a code such as 101 or 110. It also restarts a transaction in mid data byte. A design that latched partial bytes, or that kept its bit count across the start, would corrupt a register or lose alignment on the next write. It sends wrong addresses followed by valid-looking bytes, which catches a slave that resumes listening after a mismatch. It reads under each detected mode with either select-pin level, which exposes swapped nibbles, reversed bit order or a wrong address bit.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;

    localparam logic [5:0] DEV_ID_HI = 6'b100001;

    localparam logic [2:0] FN_MODE = 3'b000;
    localparam logic [2:0] FN_MUTE = 3'b001;
    localparam logic [2:0] FN_TEST = 3'b010;
    localparam logic [2:0] FN_SEP  = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_HOLD
    } link_st_e;

    function automatic logic [7:0] status_byte(input logic [1:0] det);
        case (det)
            2'b00:   return 8'h03;
            2'b01:   return 8'h06;
            2'b10:   return 8'h09;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sr;
        logic [STAGES-1:0] sda_sr;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;
    logic  scl_now, sda_now;

    assign scl_now = q.scl_sr[STAGES-1];
    assign sda_now = q.sda_sr[STAGES-1];

    generate
        if (STAGES > 1) begin : g_chain
            always_comb begin
                d          = q;
                d.scl_sr   = {q.scl_sr[STAGES-2:0], scl_i};
                d.sda_sr   = {q.sda_sr[STAGES-2:0], sda_i};
                d.scl_prev = scl_now;
                d.sda_prev = sda_now;
            end
        end else begin : g_single
            always_comb begin
                d          = q;
                d.scl_sr   = scl_i;
                d.sda_sr   = sda_i;
                d.scl_prev = scl_now;
                d.sda_prev = sda_now;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~q.scl_prev;
    assign scl_fall_o = ~scl_now & q.scl_prev;
    assign start_o    = scl_now & q.scl_prev & q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & q.scl_prev & ~q.sda_prev & sda_now;

endmodule

// File: rtl/tw_link_fsm.sv
module tw_link_fsm
    import tw_ctrl_pkg::*;
#(
    parameter int VAL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             addr_sel_i,
    input  logic [1:0]       det_mode_i,
    output logic             sda_pull_o,
    output logic             wr_stb_o,
    output logic [2:0]       wr_func_o,
    output logic [VAL_W-1:0] wr_val_o
);
    typedef struct packed {
        link_st_e   st;
        logic [1:0] byte_idx;
        logic [2:0] bit_cnt;
        logic       full;
        logic [7:0] shreg;
        logic       rw;
        logic [2:0] func;
        logic       pull;
        logic       wr_stb;
    } link_t;

    link_t      q, d;
    logic [6:0] dev_addr;

    assign dev_addr = {DEV_ID_HI, ~addr_sel_i};

    always_comb begin
        d        = q;
        d.wr_stb = 1'b0;
        if (start_i) begin
            d.st       = ST_RX;
            d.byte_idx = 2'd0;
            d.bit_cnt  = 3'd0;
            d.full     = 1'b0;
            d.pull     = 1'b0;
        end else if (stop_i) begin
            d.st   = ST_IDLE;
            d.full = 1'b0;
            d.pull = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise_i) begin
                        d.shreg   = {q.shreg[6:0], sda_i};
                        d.bit_cnt = q.bit_cnt + 3'd1;
                        if (q.bit_cnt == 3'd7) d.full = 1'b1;
                    end else if (scl_fall_i && q.full) begin
                        d.full = 1'b0;
                        if (q.byte_idx == 2'd0) begin
                            if (q.shreg[7:1] == dev_addr) begin
                                d.rw   = q.shreg[0];
                                d.pull = 1'b1;
                                d.st   = ST_ACK;
                            end else begin
                                d.st = ST_HOLD;
                            end
                        end else begin
                            if (q.byte_idx == 2'd1) d.func   = q.shreg[7:5];
                            else                    d.wr_stb = 1'b1;
                            d.pull = 1'b1;
                            d.st   = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        d.pull     = 1'b0;
                        d.byte_idx = q.byte_idx + 2'd1;
                        d.bit_cnt  = 3'd0;
                        if (q.byte_idx == 2'd1 && q.rw) begin
                            d.st    = ST_TX;
                            d.shreg = status_byte(det_mode_i);
                            d.pull  = ~d.shreg[7];
                        end else if (q.byte_idx == 2'd2) begin
                            d.st = ST_HOLD;
                        end else begin
                            d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (q.bit_cnt == 3'd7) begin
                            d.pull = 1'b0;
                            d.st   = ST_MACK;
                        end else begin
                            d.shreg   = {q.shreg[6:0], 1'b0};
                            d.bit_cnt = q.bit_cnt + 3'd1;
                            d.pull    = ~d.shreg[7];
                        end
                    end
                end
                ST_MACK: if (scl_fall_i) d.st = ST_HOLD;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_pull_o = q.pull;
    assign wr_stb_o   = q.wr_stb;
    assign wr_func_o  = q.func;
    assign wr_val_o   = q.shreg[7 -: VAL_W];

    // R3
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.st == ST_RX && q.bit_cnt == 3'd0 && q.byte_idx == 2'd0 && !sda_pull_o));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (!sda_pull_o && q.st == ST_IDLE));

    // R11
    write_on_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (!q.rw && q.byte_idx == 2'd2 && sda_pull_o));

endmodule

// File: rtl/tw_func_regs.sv
module tw_func_regs
    import tw_ctrl_pkg::*;
#(
    parameter int VAL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb_i,
    input  logic [2:0]       wr_func_i,
    input  logic [VAL_W-1:0] wr_val_i,
    output logic [1:0]       mode_o,
    output logic             mute_o,
    output logic             test_o,
    output logic [VAL_W-1:0] sep_o
);
    localparam logic [VAL_W-1:0] SEP_RST = 1 << (VAL_W - 1);

    typedef struct packed {
        logic [1:0]       mode;
        logic             mute;
        logic             test;
        logic [VAL_W-1:0] sep;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_stb_i) begin
            case (wr_func_i)
                FN_MODE: d.mode = wr_val_i[VAL_W-1 -: 2];
                FN_MUTE: d.mute = wr_val_i[VAL_W-1];
                FN_TEST: d.test = wr_val_i[VAL_W-1];
                FN_SEP:  d.sep  = wr_val_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{mode: 2'b00, mute: 1'b0, test: 1'b0, sep: SEP_RST};
        else        q <= d;
    end

    assign mode_o = q.mode;
    assign mute_o = q.mute;
    assign test_o = q.test;
    assign sep_o  = q.sep;

    // R5
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_func_i == FN_MODE) |=> mode_o == $past(wr_val_i[VAL_W-1 -: 2]));

    // R7
    sep_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_func_i == FN_SEP) |=> sep_o == $past(wr_val_i));

    // R8
    bad_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && (wr_func_i == 3'b011 || wr_func_i[2:1] == 2'b11 || wr_func_i == 3'b101))
        |=> ($stable(mode_o) && $stable(mute_o) && $stable(test_o) && $stable(sep_o)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> ($stable(mode_o) && $stable(mute_o) && $stable(test_o) && $stable(sep_o)));

endmodule

// File: rtl/tw_ctrl_regs.sv
module tw_ctrl_regs
    import tw_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SEP_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel_i,
    input  logic [1:0]       det_mode_i,
    output logic             sda_pull_o,
    output logic [1:0]       mode_o,
    output logic             mute_o,
    output logic             test_o,
    output logic [SEP_W-1:0] sep_adj_o
);
    logic             sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic             wr_stb;
    logic [2:0]       wr_func;
    logic [SEP_W-1:0] wr_val;

    tw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    tw_link_fsm #(.VAL_W(SEP_W)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .addr_sel_i (addr_sel_i),
        .det_mode_i (det_mode_i),
        .sda_pull_o (sda_pull_o),
        .wr_stb_o   (wr_stb),
        .wr_func_o  (wr_func),
        .wr_val_o   (wr_val)
    );

    tw_func_regs #(.VAL_W(SEP_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb),
        .wr_func_i (wr_func),
        .wr_val_i  (wr_val),
        .mode_o    (mode_o),
        .mute_o    (mute_o),
        .test_o    (test_o),
        .sep_o     (sep_adj_o)
    );

endmodule

// File: tb/sim_tw_ctrl_regs.sv
module sim_tw_ctrl_regs;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sel = 1'b1;
    logic [1:0] det = 2'b00;
    logic       pull;
    logic [1:0] mode;
    logic       mute, test;
    logic [4:0] sep;
    wire        sda_line = m_sda & ~pull;

    tw_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_sel_i(sel), .det_mode_i(det), .sda_pull_o(pull),
        .mode_o(mode), .mute_o(mute), .test_o(test), .sep_adj_o(sep)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0] e_mode = 2'b00;
    logic       e_mute = 1'b0, e_test = 1'b0;
    logic [4:0] e_sep  = 5'b10000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        wclk(HALF/2); m_sda = b; wclk(HALF/2);
        scl = 1'b1; wclk(HALF); scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; wclk(HALF);
        scl = 1'b1; wclk(HALF/2); b = sda_line; wclk(HALF/2); scl = 1'b0;
    endtask

    task automatic bus_start();
        wclk(HALF/2); m_sda = 1'b1; wclk(HALF/2);
        scl = 1'b1; wclk(HALF/2); m_sda = 1'b0; wclk(HALF/2); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(HALF/2); m_sda = 1'b0; wclk(HALF/2);
        scl = 1'b1; wclk(HALF/2); m_sda = 1'b1; wclk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_in(b);
            v[i] = b;
        end
        bit_out(1'b1);
    endtask

    function automatic logic addr_hit(input logic [7:0] a, input logic s);
        return a[7:1] == {6'b100001, ~s};
    endfunction

    function automatic logic [7:0] exp_status(input logic [1:0] dm);
        case (dm)
            2'b00:   return 8'h03;
            2'b01:   return 8'h06;
            2'b10:   return 8'h09;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] sub, input logic [7:0] dat);
        case (sub[7:5])
            3'b000: e_mode = dat[7:6];
            3'b001: e_mute = dat[7];
            3'b010: e_test = dat[7];
            3'b100: e_sep  = dat[7:3];
            default: ;
        endcase
    endtask

    task automatic check_regs(input string req);
        chk(req, {30'd0, mode}, {30'd0, e_mode});
        chk(req, {31'd0, mute}, {31'd0, e_mute});
        chk(req, {31'd0, test}, {31'd0, e_test});
        chk(req, {27'd0, sep},  {27'd0, e_sep});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] sub,
                            input logic [7:0] dat, input string req);
        logic a0, a1, a2, hit;
        hit = addr_hit(a, sel) && !a[0];
        bus_start();
        send_byte(a, a0);
        chk({req, " R1 addr ack"}, {31'd0, a0}, {31'd0, hit});
        wclk(6);
        chk("R2 release after ack", {31'd0, pull}, 32'd0);
        send_byte(sub, a1);
        send_byte(dat, a2);
        bus_stop();
        wclk(4);
        if (hit) begin
            chk("R8 sub ack", {31'd0, a1}, 32'd1);
            chk("R2 data ack", {31'd0, a2}, 32'd1);
            model_write(sub, dat);
        end else begin
            chk("R12 ignored after nack", {30'd0, a1, a2}, 32'd0);
        end
        chk("R2 idle after stop", {31'd0, pull}, 32'd0);
        check_regs(req);
    endtask

    task automatic do_read(input logic [7:0] sub, input string req);
        logic       a0, a1;
        logic [7:0] v;
        bus_start();
        send_byte({6'b100001, ~sel, 1'b1}, a0);
        chk("R1 read addr ack", {31'd0, a0}, 32'd1);
        send_byte(sub, a1);
        chk("R9 read sub ack", {31'd0, a1}, 32'd1);
        recv_byte(v);
        bus_stop();
        wclk(4);
        chk(req, {24'd0, v}, {24'd0, exp_status(det)});
        check_regs("R9 read leaves registers");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic ab;
        int unsigned seed_val;
        seed_val = $urandom(32'd4711);
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        // R10 reset values
        chk("R10 pull", {31'd0, pull}, 32'd0);
        check_regs("R10 reset");

        // R5 each mode encoding, R4 function select
        do_write(8'h84, 8'h00, 8'h80, "R5 stereo");
        do_write(8'h84, 8'h1F, 8'h40, "R5 bilingual");
        do_write(8'h84, 8'h00, 8'hC0, "R5 sub");
        // R6 mute and test
        do_write(8'h84, 8'h20, 8'h80, "R6 mute on");
        do_write(8'h84, 8'h40, 8'h80, "R6 test on");
        // R7 separation extremes
        do_write(8'h84, 8'h80, 8'hF8, "R7 sep max");
        do_write(8'h84, 8'h80, 8'h07, "R7 sep min");
        // R8 unused function codes
        do_write(8'h84, 8'h60, 8'hFF, "R8 code 011");
        do_write(8'h84, 8'hA0, 8'hFF, "R8 code 101");
        do_write(8'h84, 8'hC0, 8'hFF, "R8 code 110");
        do_write(8'h84, 8'hE0, 8'hFF, "R8 code 111");
        // R12 wrong addresses
        do_write(8'h86, 8'h00, 8'h40, "R12 other pin address");
        do_write(8'hA4, 8'h80, 8'hF8, "R12 foreign address");
        // R1 second address
        sel = 1'b0;
        do_write(8'h86, 8'h00, 8'h80, "R1 alt address write");
        do_write(8'h84, 8'h00, 8'h40, "R1 primary ignored when low");
        sel = 1'b1;

        // R3 / R11 start in mid data byte
        bus_start();
        send_byte(8'h84, ab);
        send_byte(8'h00, ab);
        for (int i = 0; i < 5; i++) bit_out(1'b1);
        bus_start();
        send_byte(8'h84, ab);
        chk("R3 ack after restart", {31'd0, ab}, 32'd1);
        send_byte(8'h20, ab);
        send_byte(8'h00, ab);
        bus_stop();
        wclk(4);
        e_mute = 1'b0;
        check_regs("R11 aborted write");
        // R3 start in mid address byte
        bus_start();
        for (int i = 0; i < 3; i++) bit_out(1'b1);
        bus_start();
        send_byte(8'h84, ab);
        chk("R3 ack after addr restart", {31'd0, ab}, 32'd1);
        bus_stop();
        wclk(4);

        // R9 reads under each detected mode and select level
        for (int k = 0; k < 8; k++) begin
            det = k[1:0];
            sel = k[2];
            do_read(8'($urandom), "R9 status byte");
        end
        sel = 1'b1;

        // random mix
        for (int k = 0; k < 50; k++) begin
            int unsigned r;
            r = $urandom % 8;
            if (r == 0) begin
                det = 2'($urandom);
                do_read(8'($urandom), "R9 random read");
            end else if (r == 1) begin
                do_write(8'($urandom) & 8'hFE, 8'($urandom), 8'($urandom), "R12 random address");
            end else begin
                do_write({6'b100001, ~sel, 1'b0}, 8'($urandom), 8'($urandom), "R4 random write");
            end
            if (r == 7) sel = ~sel;
        end
        finish_run();
    end
endmodule